// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This core executes one 32-bit instruction per clock from a small built-in program. It fetches from a word-organised instruction memory, decodes the opcode and function fields, reads two source registers, and computes a result. It then writes a register, writes data memory or redirects the program counter on the next rising edge. The instruction subset covers register-register logic and arithmetic, word load and store, branch-if-equal and an absolute jump. NAND and NOR sit in the function space next to the usual logic operations.

Synchronous reset clears the program counter and loads known contents into the instruction memory, the register file and the data memory. The core has no data inputs. It is observed through a debug program-counter output and a debug register read port that is selected by a 5-bit index. This makes the core useful as an integration and bring-up vehicle for the datapath units it contains.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. Register i is loaded with i*32'h1111_1111, truncated to 32 bits. Data word k is loaded with 32'hD000_0000+k.
- R2: Register 0 always reads as zero, and an instruction that targets it leaves it at zero.
- R3: An R-type instruction (opcode 000000) writes rd with the result of its funct field: 100100 AND, 100101 OR, 100110 NOR, 100111 NAND, 100000 ADD, 100010 SUB, 101010 signed set-less-than. Any other funct writes nothing.
- R4: Load word (100011) writes rt with the data word at byte address rs + sign-extended imm[15:0]. Store word (101011) writes rt to that word. Both use word index address[5:2].
- R5: Every other instruction advances the PC by 4 on each clock.
- R6: Branch-if-equal (000100) with rs equal to rt sets the PC to PC+4 + (sign-extended imm << 2). When rs and rt differ, the PC advances by 4.
- R7: Jump (000010) sets the PC to {PC+4[31:28], target[25:0], 2'b00}.
- R8: Any other opcode writes no register and no memory, and advances the PC by 4.
- R9: The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. The built-in program, as word: instruction, is:
  - 0..7: AND r16; OR r17; NOR r18; NAND r19; ADD r20; SUB r21, all with sources r3 and r5. Then SLT r22,r8,r1 and SLT r23,r1,r8.
  - 8: LW r24,4(r0)
  - 9: SW r20,8(r0)
  - 10: LW r25,8(r0)
  - 11: ADD r0,r1,r2
  - 12: opcode 001000 with rt=26
  - 13: R-type funct 100001 with rd=28
  - 14: BEQ r1,r2,+5
  - 15: J 20
  - 16..19: ADD r27,r1,r1
  - 20: BEQ r0,r0,-21
  - all other words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset and memory preload |
| dbg_sel | input | 5 | Register index for the debug read port |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_reg | output | 32 | Contents of register `dbg_sel`, zero for index 0 |

## Verification
A wrong next-PC choice appears at `dbg_pc` one clock after the faulty instruction. This is because the PC trace of the built-in program is fixed and repeats every 17 cycles. A wrong ALU result, load address or store shows up in the target register through `dbg_reg` once the first pass of the loop has finished. Because the loop is idempotent, a corrupted value stays visible for the rest of the run. A skipped write guard on register 0, or on an unsupported opcode or funct, shows as a changed value in r0, r26 or r28. A jump or branch that lands on the wrong word shows as a PC mismatch, and an execution of the skipped words shows as a modified r27.

// File: rtl/scpu_core.sv
module scpu_core #(
  parameter int          IMEM_WORDS     = 32,
  parameter int          DMEM_WORDS     = 16,
  parameter logic [31:0] REG_INIT_STEP  = 32'h1111_1111,
  parameter logic [31:0] DMEM_INIT_BASE = 32'hD000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_pc,
  output logic [31:0] dbg_reg
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam logic [5:0] OP_R = 6'b000000, OP_LW = 6'b100011, OP_SW = 6'b101011,
                         OP_BEQ = 6'b000100, OP_J = 6'b000010;

  function automatic logic [31:0] rw(input logic [4:0] s, input logic [4:0] t,
                                     input logic [4:0] d, input logic [5:0] f);
    return {OP_R, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] iw(input logic [5:0] o, input logic [4:0] s,
                                     input logic [4:0] t, input logic [15:0] im);
    return {o, s, t, im};
  endfunction
  function automatic logic [31:0] prog_word(input int k);
    case (k)
      0:  return rw(5'd3, 5'd5, 5'd16, 6'b100100);
      1:  return rw(5'd3, 5'd5, 5'd17, 6'b100101);
      2:  return rw(5'd3, 5'd5, 5'd18, 6'b100110);
      3:  return rw(5'd3, 5'd5, 5'd19, 6'b100111);
      4:  return rw(5'd3, 5'd5, 5'd20, 6'b100000);
      5:  return rw(5'd3, 5'd5, 5'd21, 6'b100010);
      6:  return rw(5'd8, 5'd1, 5'd22, 6'b101010);
      7:  return rw(5'd1, 5'd8, 5'd23, 6'b101010);
      8:  return iw(OP_LW, 5'd0, 5'd24, 16'd4);
      9:  return iw(OP_SW, 5'd0, 5'd20, 16'd8);
      10: return iw(OP_LW, 5'd0, 5'd25, 16'd8);
      11: return rw(5'd1, 5'd2, 5'd0, 6'b100000);
      12: return iw(6'b001000, 5'd0, 5'd26, 16'd1);
      13: return rw(5'd1, 5'd2, 5'd28, 6'b100001);
      14: return iw(OP_BEQ, 5'd1, 5'd2, 16'd5);
      15: return {OP_J, 26'd20};
      16, 17, 18, 19: return rw(5'd1, 5'd1, 5'd27, 6'b100000);
      20: return iw(OP_BEQ, 5'd0, 5'd0, -16'sd21);
      default: return 32'd0;
    endcase
  endfunction

  logic [31:0] pc;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] instr;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd;
  assign instr = imem[pc[IAW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];

  logic [31:0] rs_val, rt_val;
  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];

  logic is_r, is_lw, is_sw, is_beq, is_j;
  assign is_r   = (op == OP_R);
  assign is_lw  = (op == OP_LW);
  assign is_sw  = (op == OP_SW);
  assign is_beq = (op == OP_BEQ);
  assign is_j   = (op == OP_J);

  logic [31:0] alu_y;
  logic        alu_ok;
  always_comb begin
    alu_ok = 1'b1;
    alu_y  = 32'd0;
    case (funct)
      6'b100100: alu_y = rs_val & rt_val;
      6'b100101: alu_y = rs_val | rt_val;
      6'b100110: alu_y = ~(rs_val | rt_val);
      6'b100111: alu_y = ~(rs_val & rt_val);
      6'b100000: alu_y = rs_val + rt_val;
      6'b100010: alu_y = rs_val - rt_val;
      6'b101010: alu_y = {31'd0, $signed(rs_val) < $signed(rt_val)};
      default:   alu_ok = 1'b0;
    endcase
  end

  logic [31:0] imm_sx, mem_addr, pc_plus4, br_tgt, next_pc;
  logic [DAW-1:0] didx;
  assign imm_sx   = {{16{instr[15]}}, instr[15:0]};
  assign mem_addr = rs_val + imm_sx;
  assign didx     = mem_addr[DAW+1:2];
  assign pc_plus4 = pc + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
  assign next_pc  = is_j ? {pc_plus4[31:28], instr[25:0], 2'b00}
                  : (is_beq && rs_val == rt_val) ? br_tgt : pc_plus4;

  logic        wr_en;
  logic [4:0]  wr_dst;
  logic [31:0] wr_data;
  assign wr_en   = (is_r && alu_ok) || is_lw;
  assign wr_dst  = is_r ? rd : rt;
  assign wr_data = is_lw ? dmem[didx] : alu_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'(i) * REG_INIT_STEP;
      for (int k = 0; k < DMEM_WORDS; k++) dmem[k] <= DMEM_INIT_BASE + 32'(k);
    end else begin
      pc <= next_pc;
      if (wr_en && wr_dst != 5'd0) rf[wr_dst] <= wr_data;
      if (is_sw) dmem[didx] <= rt_val;
    end
  end

  always_ff @(posedge clk)
    if (rst)
      for (int k = 0; k < IMEM_WORDS; k++) imem[k] <= prog_word(k);

  assign dbg_pc  = pc;
  assign dbg_reg = (dbg_sel == 5'd0) ? 32'd0 : rf[dbg_sel];

  a_r2_zero_reg: assert property (@(posedge clk) disable iff (rst) rf[0] == 32'd0);
  a_r5_pc_aligned: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);
  a_r8_unknown_op_advances: assert property (@(posedge clk) disable iff (rst)
    !(is_r || is_lw || is_sw || is_beq || is_j) |=> pc == $past(pc) + 32'd4);
  a_r7_jump_region: assert property (@(posedge clk) disable iff (rst)
    is_j |=> pc[31:28] == $past(pc_plus4[31:28]));
  a_r4_store_lands: assert property (@(posedge clk) disable iff (rst)
    is_sw |=> dmem[$past(didx)] == $past(rt_val));
  a_r6_beq_unequal: assert property (@(posedge clk) disable iff (rst)
    (is_beq && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);
endmodule

// File: tb/scpu_core_tb.sv
`timescale 1ns/1ps
module scpu_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dbg_sel = 5'd0;
  logic [31:0] dbg_pc, dbg_reg;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  scpu_core u_dut (.clk(clk), .rst(rst), .dbg_sel(dbg_sel), .dbg_pc(dbg_pc), .dbg_reg(dbg_reg));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] init_reg(input int i);
    return 32'(i) * 32'h1111_1111;
  endfunction

  function automatic logic [31:0] exp_reg(input int i);
    logic [31:0] a, b;
    a = init_reg(3);
    b = init_reg(5);
    case (i)
      0:  return 32'd0;
      16: return a & b;
      17: return a | b;
      18: return ~(a | b);
      19: return ~(a & b);
      20: return a + b;
      21: return a - b;
      22: return {31'd0, $signed(init_reg(8)) < $signed(init_reg(1))};
      23: return {31'd0, $signed(init_reg(1)) < $signed(init_reg(8))};
      24: return 32'hD000_0001;
      25: return a + b;
      default: return init_reg(i);
    endcase
  endfunction

  function automatic logic [31:0] exp_pc(input int n);
    int m = n % 17;
    return (m == 16) ? 32'd80 : 32'(4 * m);
  endfunction

  function automatic string reg_tag(input int i);
    if (i == 0) return "R2";
    if (i >= 16 && i <= 23) return "R3";
    if (i == 28) return "R3";
    if (i == 24 || i == 25) return "R4";
    if (i == 26) return "R8";
    if (i == 27) return "R7";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic read_reg(input int i, input string tag, input logic [31:0] exp);
    dbg_sel = 5'(i);
    #0.5;
    check(tag, dbg_reg, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc reset", dbg_pc, 32'd0);
    for (int j = 0; j < 8; j++) begin
      int i = int'($urandom_range(31, 1));
      read_reg(i, "R1 reg init", init_reg(i));
    end
    read_reg(0, "R2 r0 reads zero", 32'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < 60; n++) begin
      #0.5;
      if (n % 17 == 16) check("R7 jump to word 20", dbg_pc, exp_pc(n));
      else if (n > 0 && n % 17 == 0) check("R6 beq back to 0", dbg_pc, exp_pc(n));
      else if (n % 17 == 15) check("R6 beq not taken", dbg_pc, exp_pc(n));
      else if (n % 17 == 13) check("R8 no-op advances", dbg_pc, exp_pc(n));
      else check("R5 pc step", dbg_pc, exp_pc(n));
      @(negedge clk);
    end
    for (int i = 0; i < 32; i++) read_reg(i, reg_tag(i), exp_reg(i));
    for (int j = 0; j < 40; j++) begin
      int i = int'($urandom_range(31, 0));
      read_reg(i, {reg_tag(i), " R9 random read"}, exp_reg(i));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule